// File: doc/BRIEF.md
# Trimmed 100 Hz Timebase Prescaler

This block turns a 32.768 kHz oscillator clock into a nominal 100 Hz timebase. A phase accumulator adds a fixed increment on every enabled oscillator cycle and raises a one-cycle tick each time it wraps. The tick feeds the timekeeping counters. A second output gives a 100 Hz wave with roughly 20% duty. It lets an outside instrument measure the oscillator error.

The oscillator runs slightly fast, and the frequency is never adjusted. Instead, a repeating correction window of fixed length (31 s of oscillator cycles by default) suspends the accumulator for the first N cycles of each window. N is an 8-bit trim value, and each step slows the timebase by about 0.984 ppm. Writes to the trim value can be locked out. A test input turns all suspension off.

Top module: `trimmed_prescaler`

## Requirements
- R1: After a synchronous reset, `tick` and `cal_wave` are low, the accumulator and window position are zero, and the trim value is D2 hex (210).
- R2: With no suspension active, every enabled cycle adds INC (default 100) to a 15-bit accumulator modulo 32768. `tick` goes high in the cycle after the clock edge on which the sum wraps. Exactly 100 ticks occur in any 32768 consecutive enabled cycles.
- R3: A window position counter runs 0 to WINDOW-1 and then wraps (default 1,015,808 cycles). Position 0 is the first cycle after reset. In each window, the accumulator is held during the cycles whose position is less than the current trim value.
- R4: `tick` is a single-cycle pulse: it is never high in two consecutive cycles.
- R5: While `trim_lock` is high, a write strobe on the trim port leaves the trim value unchanged.
- R6: While `no_correct` is high, the accumulator advances on every cycle, whatever the trim value.
- R7: `cal_wave` goes high in the same cycle as each `tick`. It stays high for HI_CYC cycles (65 by default, which is 20% of the 327.68-cycle period) and is then low until the next tick.
- R8: An unlocked write stores `trim_data` at that clock edge. The new value governs suspension from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| trim_we | input | 1 | Trim write strobe |
| trim_data | input | 8 | Trim value to store |
| trim_lock | input | 1 | Blocks trim writes when high |
| no_correct | input | 1 | Disables cycle suspension when high |
| tick | output | 1 | One-cycle 100 Hz timebase pulse |
| cal_wave | output | 1 | 100 Hz calibration wave, about 20% duty |

## Verification
A wrong accumulator value or a wrong suspension count moves the position of the next tick. It therefore appears at the `tick` port within one tick period of about 328 cycles. A wrong window position or a wrong stored trim value shows only when a window boundary passes. The bench therefore uses a short window, so that such an error appears within a few thousand cycles as a shifted tick. A bad pulse-width counter shows on `cal_wave` at the next falling edge of the wave. The reference model is compared with both outputs on every cycle, so the first cycle that differs is reported.

// File: rtl/tp_pkg.sv
package tp_pkg;
   localparam int TRIM_W = 8;
   typedef logic [TRIM_W-1:0] trim_t;
   localparam trim_t TRIM_DEFAULT = 8'hD2;
endpackage

// File: rtl/tp_window.sv
module tp_window #(
   parameter int WINDOW = 1015808,
   parameter int TRIM_W = 8,
   localparam int WIN_W = $clog2(WINDOW)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [TRIM_W-1:0] trim,
   input  logic              bypass,
   output logic              adv,
   output logic [WIN_W-1:0]  pos
);
   localparam logic [WIN_W-1:0] LAST = WIN_W'(WINDOW - 1);

   generate
      if (WINDOW <= (1 << TRIM_W)) begin : g_bad_window
         $error("WINDOW must exceed the largest trim value");
      end
   endgenerate

   logic [WIN_W-1:0] trim_ext;
   assign trim_ext = {{(WIN_W-TRIM_W){1'b0}}, trim};

   always_ff @(posedge clk) begin
      if (rst)              pos <= '0;
      else if (pos == LAST) pos <= '0;
      else                  pos <= pos + 1'b1;
   end

   assign adv = bypass | (pos >= trim_ext);

   // R3
   window_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (pos == LAST) |=> (pos == '0));
endmodule

// File: rtl/tp_phase_acc.sv
module tp_phase_acc #(
   parameter int ACC_W = 15,
   parameter int INC   = 100
) (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   output logic wrap,
   output logic tick
);
   generate
      if (INC <= 0 || INC >= (1 << ACC_W)) begin : g_bad_inc
         $error("INC must lie between 1 and 2**ACC_W-1");
      end
   endgenerate

   logic [ACC_W-1:0] acc;
   logic [ACC_W:0]   sum;

   assign sum  = {1'b0, acc} + (ACC_W+1)'(INC);
   assign wrap = adv & sum[ACC_W];

   always_ff @(posedge clk) begin
      if (rst) begin
         acc  <= '0;
         tick <= 1'b0;
      end else begin
         if (adv) acc <= sum[ACC_W-1:0];
         tick <= wrap;
      end
   end

   // R4
   tick_single_chk: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);
   // R2
   hold_acc_chk: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(acc));
endmodule

// File: rtl/tp_cal_pulse.sv
module tp_cal_pulse #(
   parameter int HI_CYC = 65,
   localparam int CNT_W = $clog2(HI_CYC + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic wave
);
   generate
      if (HI_CYC == 0) begin : g_none
         assign wave = 1'b0;
      end else begin : g_cnt
         logic [CNT_W-1:0] left;
         always_ff @(posedge clk) begin
            if (rst)             left <= '0;
            else if (start)      left <= CNT_W'(HI_CYC);
            else if (left != '0) left <= left - 1'b1;
         end
         assign wave = (left != '0);
      end
   endgenerate
endmodule

// File: rtl/trimmed_prescaler.sv
module trimmed_prescaler #(
   parameter int           WINDOW   = 1015808,
   parameter int           ACC_W    = 15,
   parameter int           INC      = 100,
   parameter int           DUTY_PCT = 20,
   parameter tp_pkg::trim_t TRIM_RST = tp_pkg::TRIM_DEFAULT
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       trim_we,
   input  logic [7:0] trim_data,
   input  logic       trim_lock,
   input  logic       no_correct,
   output logic       tick,
   output logic       cal_wave
);
   import tp_pkg::*;
   localparam int HI_CYC = ((1 << ACC_W) * DUTY_PCT) / (INC * 100);
   localparam int WIN_W  = $clog2(WINDOW);

   generate
      if (DUTY_PCT < 0 || DUTY_PCT > 100) begin : g_bad_duty
         $error("DUTY_PCT must lie between 0 and 100");
      end
   endgenerate

   trim_t            trim_q;
   logic             adv;
   logic             wrap;
   logic [WIN_W-1:0] win_pos;

   always_ff @(posedge clk) begin
      if (rst)                        trim_q <= TRIM_RST;
      else if (trim_we && !trim_lock) trim_q <= trim_data;
   end

   tp_window #(.WINDOW(WINDOW), .TRIM_W(TRIM_W)) u_window (
      .clk(clk), .rst(rst), .trim(trim_q), .bypass(no_correct),
      .adv(adv), .pos(win_pos));

   tp_phase_acc #(.ACC_W(ACC_W), .INC(INC)) u_acc (
      .clk(clk), .rst(rst), .adv(adv), .wrap(wrap), .tick(tick));

   tp_cal_pulse #(.HI_CYC(HI_CYC)) u_cal (
      .clk(clk), .rst(rst), .start(wrap), .wave(cal_wave));

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> (!tick && !cal_wave));
   // R5
   lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (trim_lock && trim_we) |=> $stable(trim_q));
   // R6
   bypass_adv_chk: assert property (@(posedge clk) disable iff (rst)
      no_correct |-> adv);
   // R7
   wave_start_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(cal_wave) |-> tick);
   // R3
   early_window_chk: assert property (@(posedge clk) disable iff (rst)
      !adv |-> (win_pos < WIN_W'(trim_q)));
endmodule

// File: tb/tb_trimmed_prescaler.sv
module tb_trimmed_prescaler;
   localparam int WIN = 3000;
   localparam int MOD = 32768;
   localparam int INC = 100;
   localparam int HI  = (MOD * 20) / (INC * 100);

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       trim_we = 1'b0;
   logic [7:0] trim_data = 8'h00;
   logic       trim_lock = 1'b0;
   logic       no_correct = 1'b0;
   logic       tick, cal_wave;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   string req = "R3";

   // reference model state
   int m_win = 0, m_acc = 0, m_trim = 210, m_wc = 0;
   bit m_tick = 1'b0;

   always #2.5 clk = ~clk;

   trimmed_prescaler #(.WINDOW(WIN)) dut (
      .clk(clk), .rst(rst), .trim_we(trim_we), .trim_data(trim_data),
      .trim_lock(trim_lock), .no_correct(no_correct),
      .tick(tick), .cal_wave(cal_wave));

   always @(posedge clk) begin
      bit en, fire;
      cyc++;
      if (rst) begin
         m_win = 0; m_acc = 0; m_trim = 210; m_wc = 0; m_tick = 1'b0;
      end else begin
         en   = no_correct || (m_win >= m_trim);
         fire = en && (m_acc + INC >= MOD);
         if (en) m_acc = (m_acc + INC) % MOD;
         m_tick = fire;
         if (fire) m_wc = HI;
         else if (m_wc > 0) m_wc--;
         m_win = (m_win == WIN - 1) ? 0 : m_win + 1;
         if (trim_we && !trim_lock) m_trim = int'(trim_data);
      end
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog (all) actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (!rst) begin
         checks++;
         if (tick !== m_tick) begin
            errors++;
            $display("FAIL %s tick actual=%0b expected=%0b cyc=%0d", req, tick, m_tick, cyc);
         end
         checks++;
         if (cal_wave !== (m_wc > 0)) begin
            errors++;
            $display("FAIL R7 cal_wave actual=%0b expected=%0b cyc=%0d", cal_wave, (m_wc > 0), cyc);
         end
      end
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_trim(input logic [7:0] v);
      @(negedge clk);
      trim_we = 1'b1; trim_data = v;
      @(negedge clk);
      trim_we = 1'b0;
   endtask

   initial begin
      int cnt;
      run(3);
      rst = 1'b0;
      // R1: reset state at the first cycle after reset
      @(negedge clk);
      checks++;
      if (tick !== 1'b0 || cal_wave !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset outputs actual=%0b%0b expected=00", tick, cal_wave);
      end
      req = "R3";  run(7000);
      req = "R8";  write_trim(8'h00);
      req = "R2";  run(4000);
      req = "R3";  write_trim(8'hFF); run(7000);
      req = "R5";  trim_lock = 1'b1; write_trim(8'h05); run(7000);
      trim_lock = 1'b0;
      req = "R6";  no_correct = 1'b1; run(4000);
      req = "R4";  write_trim(8'h80); run(2000);
      // R2: exactly 100 ticks in 32768 enabled cycles
      req = "R2";
      cnt = 0;
      for (int i = 0; i < MOD; i++) begin
         @(negedge clk);
         if (tick) cnt++;
      end
      checks++;
      if (cnt != 100) begin
         errors++;
         $display("FAIL R2 ticks per 32768 cycles actual=%0d expected=100", cnt);
      end
      no_correct = 1'b0;
      req = "R3";  run(7000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
   end
endmodule